// File: doc/BRIEF.md
# Duo-Binary Circular Turbo Encoder

The block turns a block of N two-bit couples (A,B) into N six-bit symbols. Each symbol carries the couple itself and two parity pairs. The first pair comes from a recursive eight-state constituent encoder that sees the couples in arrival order. The second pair comes from an identical encoder that sees them permuted and, at odd source positions, with A and B swapped. Both encoders are tail-biting, so no tail bits are added and the symbol count equals the couple count.

A block enters as a valid/ready stream. The block length and the permutation constants are sampled with its first couple, and the whole block is stored on chip. A first pass over the stored data runs both encoders from the zero state. Their end states, together with N mod 7, give each encoder a starting state that makes its trellis close on itself. A second pass produces the output stream. While a block is in flight, no new couples are taken, and a block costs about 3N cycles plus a few cycles of overhead.

Top module: `duobin_turbo_enc`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` and `len_err` are 0. `in_ready` stays 1 until the N-th couple of a block is accepted.
- R2: `blk_len` is sampled with the first couple of a block. A length is legal when it lies in 56..2396 and is not a multiple of 7. On an illegal length that first couple is discarded, `len_err` is 1 in the next cycle only, no block starts, and `in_ready` stays 1.
- R3: Output bits [5:0] are A, B, Y1, W1, Y2, W2, from bit 5 down to bit 0. A and B are the couple of the same index in arrival order, with A on `in_cpl[1]` and B on `in_cpl[0]`.
- R4: Each constituent encoder has state bits s1,s2,s3. With f = A^B^s1^s3, the parity bits are Y = f^s2^s3 and W = f^s3, and the next state is s1=f, s2=s1^B, s3=s2^B. Y1,W1 come from the encoder fed in arrival order.
- R5: The second encoder's couple j is read from position P(j) = (P0*j + Q + 1) mod N. Q is 0, Q1, Q2 or Q3 for j mod 4 equal to 0, 1, 2 or 3. P0 and every Q are below N.
- R6: When P(j) is odd, A and B of that couple are exchanged before the second encoder sees it. Y2,W2 come from this encoder.
- R7: Each encoder starts the output pass in the unique state that its own couple sequence returns it to after N steps.
- R8: A block yields exactly N symbols in consecutive cycles, with `out_last` set on the N-th only.
- R9: `in_ready` is 0 while symbols are being presented and returns to 1 in the cycle after `out_last`.
- R10: The first symbol appears N+4 cycles after the cycle in which the last couple is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Couple offered |
| in_ready | output | 1 | Block is being loaded; couple taken when both are high |
| in_cpl | input | 2 | Couple, A on bit 1, B on bit 0 |
| blk_len | input | LW | Block length N in couples |
| ilv_p0 | input | LW | Permutation step P0 |
| ilv_q1 | input | LW | Offset for j mod 4 = 1 |
| ilv_q2 | input | LW | Offset for j mod 4 = 2 |
| ilv_q3 | input | LW | Offset for j mod 4 = 3 |
| len_err | output | 1 | One-cycle pulse: illegal block length rejected |
| out_valid | output | 1 | Symbol valid |
| out_sym | output | 6 | Symbol {A,B,Y1,W1,Y2,W2} |
| out_last | output | 1 | Final symbol of the block |

## Verification
The bench runs one block for every nonzero residue of N mod 7, and also blocks of the maximum length and of all-zero and all-one data. A wrong circulation-state mapping would then break the parity stream for some residue while leaving the others correct. Random data at odd and even source positions exposes a missing or misplaced A/B swap, which corrupts only Y2,W2. It also exposes a permutation offset or modular wrap taken wrongly. The bench offers lengths just below and just above the legal range and a multiple of 7. A design that failed to reject them would start a block, emit symbols or drop `in_ready`. Off-by-one pipeline or counter errors show up as a wrong symbol count, a misplaced last flag or a latency other than N+4.

// File: rtl/tbe_pkg.sv
package tbe_pkg;

    typedef logic [2:0] st_t;   // [2]=s1, [1]=s2, [0]=s3

    typedef struct packed {
        logic a;
        logic b;
    } cpl_t;

    typedef struct packed {
        logic a;
        logic b;
        logic y1;
        logic w1;
        logic y2;
        logic w2;
    } sym_t;

    typedef enum logic [2:0] {
        PH_LOAD,
        PH_PRE,
        PH_GAP,
        PH_ENC,
        PH_DRAIN
    } phase_e;

    function automatic logic rsc_fb(st_t s, cpl_t c);
        return c.a ^ c.b ^ s[2] ^ s[0];
    endfunction

    function automatic st_t rsc_next(st_t s, cpl_t c);
        logic f;
        f = rsc_fb(s, c);
        return {f, s[2] ^ c.b, s[1] ^ c.b};
    endfunction

    function automatic logic [1:0] rsc_par(st_t s, cpl_t c);
        logic f;
        f = rsc_fb(s, c);
        return {f ^ s[1] ^ s[0], f ^ s[0]};
    endfunction

    // k zero-input steps of the autonomous recursion
    function automatic st_t idle_steps(st_t s, logic [2:0] k);
        st_t r;
        r = s;
        for (int i = 0; i < 6; i++) begin
            if (i < int'(k)) r = rsc_next(r, '0);
        end
        return r;
    endfunction

    // Solve x ^ A^k x = fin over the eight candidates
    function automatic st_t circ_state(logic [2:0] k, st_t fin);
        st_t r;
        st_t t;
        r = '0;
        for (int c = 0; c < 8; c++) begin
            t = 3'(c);
            if ((t ^ idle_steps(t, k)) == fin) r = t;
        end
        return r;
    endfunction

endpackage

// File: rtl/tbe_cpl_buf.sv
module tbe_cpl_buf #(
    parameter int DEPTH = 2396,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [1:0]    wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [1:0]    rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [1:0]    rdata_b_o
);
    logic [1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
        rdata_a_o <= mem[raddr_a_i];
        rdata_b_o <= mem[raddr_b_i];
    end
endmodule

// File: rtl/tbe_perm_addr.sv
module tbe_perm_addr #(
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          adv_i,
    input  logic [LW-1:0] n_i,
    input  logic [LW-1:0] p0_i,
    input  logic [LW-1:0] q1_i,
    input  logic [LW-1:0] q2_i,
    input  logic [LW-1:0] q3_i,
    output logic [LW-1:0] nat_o,
    output logic [LW-1:0] int_o,
    output logic          swap_o,
    output logic          last_o
);
    logic [LW-1:0] j_q, acc_q, acc_nx, off;
    logic [LW:0]   n_ext, sum_raw, acc_raw;

    always_comb begin
        n_ext = {1'b0, n_i};
        unique case (j_q[1:0])
            2'd0:    off = '0;
            2'd1:    off = q1_i;
            2'd2:    off = q2_i;
            default: off = q3_i;
        endcase
        sum_raw = {1'b0, acc_q} + {1'b0, off} + (LW+1)'(1);
        int_o   = (sum_raw >= n_ext) ? LW'(sum_raw - n_ext) : LW'(sum_raw);
        acc_raw = {1'b0, acc_q} + {1'b0, p0_i};
        acc_nx  = (acc_raw >= n_ext) ? LW'(acc_raw - n_ext) : LW'(acc_raw);
    end

    assign nat_o  = j_q;
    assign swap_o = int_o[0];
    assign last_o = (j_q == n_i - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            j_q   <= '0;
            acc_q <= '0;
        end else if (adv_i) begin
            j_q   <= j_q + 1'b1;
            acc_q <= acc_nx;
        end
    end

    p_perm_range_r5: assert property (@(posedge clk) disable iff (rst)
        adv_i |-> (int_o < n_i));
    p_step_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        adv_i |=> (acc_q < n_i));
endmodule

// File: rtl/tbe_rsc.sv
module tbe_rsc
    import tbe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_i,
    input  logic       step_i,
    input  logic       wrap_i,
    input  logic       fin_i,
    input  logic [2:0] nm7_i,
    input  cpl_t       cpl_i,
    output logic [1:0] par_o
);
    st_t st_q, start_q, nxt, circ;

    assign nxt   = rsc_next(st_q, cpl_i);
    assign circ  = circ_state(nm7_i, nxt);
    assign par_o = rsc_par(st_q, cpl_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            st_q    <= '0;
            start_q <= '0;
        end else if (wrap_i) begin
            st_q    <= circ;
            start_q <= circ;
        end else if (step_i) begin
            st_q    <= nxt;
        end
    end

    // trellis closes: the last output step lands back on the start state
    p_circular_r7: assert property (@(posedge clk) disable iff (rst)
        (fin_i && step_i) |=> (st_q == start_q));
    p_wrap_alone_r7: assert property (@(posedge clk) disable iff (rst)
        wrap_i |-> !fin_i);
endmodule

// File: rtl/duobin_turbo_enc.sv
module duobin_turbo_enc
    import tbe_pkg::*;
#(
    parameter int NMIN = 56,
    parameter int NMAX = 2396,
    parameter int LW   = $clog2(NMAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [1:0]    in_cpl,
    input  logic [LW-1:0] blk_len,
    input  logic [LW-1:0] ilv_p0,
    input  logic [LW-1:0] ilv_q1,
    input  logic [LW-1:0] ilv_q2,
    input  logic [LW-1:0] ilv_q3,
    output logic          len_err,
    output logic          out_valid,
    output logic [5:0]    out_sym,
    output logic          out_last
);
    phase_e        ph_q;
    logic [LW-1:0] wcnt_q, n_q, p0_q, q1_q, q2_q, q3_q, n_eff;
    logic [2:0]    nm7_q, nm7_in;
    logic          err_q, accept, at_first, len_ok, wr_en, load_done;
    logic          issue, a_swap, a_last;
    logic [LW-1:0] a_nat, a_int;
    logic [1:0]    rd_nat, rd_int;
    logic          rd_vld_q, rd_last_q, rd_enc_q, rd_swap_q;
    logic          pre_wrap, stepping, fin;
    cpl_t          cpl_nat, cpl_int;
    logic [1:0]    par1, par2;
    sym_t          sym_q;
    logic          ov_q, ol_q;

    assign in_ready  = (ph_q == PH_LOAD);
    assign accept    = in_valid && in_ready;
    assign at_first  = (wcnt_q == '0);
    assign nm7_in    = 3'(blk_len % LW'(7));
    assign len_ok    = (blk_len >= LW'(NMIN)) && (blk_len <= LW'(NMAX)) && (nm7_in != 3'd0);
    assign n_eff     = at_first ? blk_len : n_q;
    assign wr_en     = accept && !(at_first && !len_ok);
    assign load_done = wr_en && (wcnt_q == n_eff - 1'b1);
    assign issue     = (ph_q == PH_PRE) || (ph_q == PH_ENC);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_LOAD;
            wcnt_q <= '0;
            n_q    <= '0;
            p0_q   <= '0;
            q1_q   <= '0;
            q2_q   <= '0;
            q3_q   <= '0;
            nm7_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= accept && at_first && !len_ok;
            unique case (ph_q)
                PH_LOAD: if (wr_en) begin
                    if (at_first) begin
                        n_q   <= blk_len;
                        p0_q  <= ilv_p0;
                        q1_q  <= ilv_q1;
                        q2_q  <= ilv_q2;
                        q3_q  <= ilv_q3;
                        nm7_q <= nm7_in;
                    end
                    if (load_done) begin
                        wcnt_q <= '0;
                        ph_q   <= PH_PRE;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                PH_PRE:   if (a_last) ph_q <= PH_GAP;
                PH_GAP:   ph_q <= PH_ENC;
                PH_ENC:   if (a_last) ph_q <= PH_DRAIN;
                PH_DRAIN: if (ov_q && ol_q) ph_q <= PH_LOAD;
                default:  ph_q <= PH_LOAD;
            endcase
        end
    end

    tbe_cpl_buf #(.DEPTH(NMAX), .AW(LW)) buf_i (
        .clk       (clk),
        .we_i      (wr_en),
        .waddr_i   (wcnt_q),
        .wdata_i   (in_cpl),
        .raddr_a_i (a_nat),
        .rdata_a_o (rd_nat),
        .raddr_b_i (a_int),
        .rdata_b_o (rd_int)
    );

    tbe_perm_addr #(.LW(LW)) addr_i (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (load_done || (issue && a_last)),
        .adv_i  (issue && !a_last),
        .n_i    (n_q),
        .p0_i   (p0_q),
        .q1_i   (q1_q),
        .q2_i   (q2_q),
        .q3_i   (q3_q),
        .nat_o  (a_nat),
        .int_o  (a_int),
        .swap_o (a_swap),
        .last_o (a_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld_q  <= 1'b0;
            rd_last_q <= 1'b0;
            rd_enc_q  <= 1'b0;
            rd_swap_q <= 1'b0;
        end else begin
            rd_vld_q  <= issue;
            rd_last_q <= issue && a_last;
            rd_enc_q  <= (ph_q == PH_ENC);
            rd_swap_q <= a_swap;
        end
    end

    assign pre_wrap = rd_vld_q && rd_last_q && !rd_enc_q;
    assign stepping = rd_vld_q && !pre_wrap;
    assign fin      = rd_vld_q && rd_last_q && rd_enc_q;
    assign cpl_nat  = cpl_t'(rd_nat);
    assign cpl_int  = rd_swap_q ? cpl_t'({rd_int[0], rd_int[1]}) : cpl_t'(rd_int);

    tbe_rsc enc_nat_i (
        .clk (clk), .rst (rst), .clr_i (load_done), .step_i (stepping),
        .wrap_i (pre_wrap), .fin_i (fin), .nm7_i (nm7_q), .cpl_i (cpl_nat),
        .par_o (par1)
    );

    tbe_rsc enc_int_i (
        .clk (clk), .rst (rst), .clr_i (load_done), .step_i (stepping),
        .wrap_i (pre_wrap), .fin_i (fin), .nm7_i (nm7_q), .cpl_i (cpl_int),
        .par_o (par2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q  <= 1'b0;
            ol_q  <= 1'b0;
            sym_q <= '0;
        end else begin
            ov_q  <= rd_vld_q && rd_enc_q;
            ol_q  <= fin;
            sym_q <= '{a: cpl_nat.a, b: cpl_nat.b, y1: par1[1], w1: par1[0],
                       y2: par2[1], w2: par2[0]};
        end
    end

    assign out_valid = ov_q;
    assign out_last  = ol_q;
    assign out_sym   = sym_q;
    assign len_err   = err_q;

    p_busy_no_ready_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);
    p_err_from_accept_r2: assert property (@(posedge clk) disable iff (rst)
        len_err |-> $past(in_valid && in_ready));
    p_err_single_r2: assert property (@(posedge clk) disable iff (rst)
        len_err |=> !len_err);
    p_last_valid_r8: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);
    p_ready_after_last_r9: assert property (@(posedge clk) disable iff (rst)
        out_last |=> in_ready);
endmodule

// File: tb/duobin_turbo_enc_tb_top.sv
module duobin_turbo_enc_tb_top;
    localparam int LW = 12;
    localparam int MAXN = 2396;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [1:0] in_cpl = '0;
    logic [LW-1:0] blk_len = '0, ilv_p0 = '0, ilv_q1 = '0, ilv_q2 = '0, ilv_q3 = '0;
    logic in_ready, len_err, out_valid, out_last;
    logic [5:0] out_sym;

    always #4 clk = ~clk;

    duobin_turbo_enc dut_i (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
        .in_cpl (in_cpl), .blk_len (blk_len), .ilv_p0 (ilv_p0), .ilv_q1 (ilv_q1),
        .ilv_q2 (ilv_q2), .ilv_q3 (ilv_q3), .len_err (len_err),
        .out_valid (out_valid), .out_sym (out_sym), .out_last (out_last)
    );

    int n_checks = 0;
    int n_fail = 0;
    longint cyc = 0;
    bit done = 1'b0;

    logic [5:0] got_sym [MAXN];
    logic       got_last [MAXN];
    logic [1:0] dat [MAXN];
    logic [1:0] iseq [MAXN];
    int ocnt = 0;
    int ready_viol = 0;
    longint first_cyc = 0, last_cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got cycle %0d expected below 150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (out_valid) begin
            if (ocnt < MAXN) begin
                got_sym[ocnt]  = out_sym;
                got_last[ocnt] = out_last;
            end
            if (ocnt == 0) first_cyc = cyc;
            last_cyc = cyc;
            ocnt++;
            if (in_ready) ready_viol++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one encoder step from the requirement equations (R4)
    function automatic logic [4:0] ref_step(logic [2:0] s, logic [1:0] c);
        logic a, b, s1, s2, s3, f;
        a = c[1]; b = c[0]; s1 = s[2]; s2 = s[1]; s3 = s[0];
        f = a ^ b ^ s1 ^ s3;
        return {f, s1 ^ b, s2 ^ b, f ^ s2 ^ s3, f ^ s3};
    endfunction

    function automatic logic [2:0] run_end(logic [2:0] s0, int n, bit use_i);
        logic [2:0] s;
        logic [4:0] r;
        s = s0;
        for (int j = 0; j < n; j++) begin
            r = ref_step(s, use_i ? iseq[j] : dat[j]);
            s = r[4:2];
        end
        return s;
    endfunction

    function automatic logic [2:0] find_circ(int n, bit use_i);
        logic [2:0] hit;
        hit = '0;
        for (int c = 0; c < 8; c++) begin
            if (run_end(3'(c), n, use_i) == 3'(c)) hit = 3'(c);
        end
        return hit;
    endfunction

    task automatic run_block(input int n, input int p0, input int q1, input int q2,
                             input int q3, input int mode, input string tag);
        longint acc_cyc;
        bit acc;
        int i, wait_cnt, bad_sys, bad_p1, bad_p2, bad_last;
        logic [2:0] s1, s2;
        logic [4:0] r1, r2;
        logic [5:0] exp;
        $display("block %s N=%0d", tag, n);
        for (int k = 0; k < n; k++) begin
            case (mode)
                0: dat[k] = 2'($urandom_range(0, 3));
                1: dat[k] = 2'b00;
                2: dat[k] = 2'b11;
                default: dat[k] = (k % 2 == 0) ? 2'b10 : 2'b01;
            endcase
        end
        for (int j = 0; j < n; j++) begin
            int q, p;
            q = (j % 4 == 0) ? 0 : (j % 4 == 1) ? q1 : (j % 4 == 2) ? q2 : q3;
            p = int'((longint'(p0) * j + q + 1) % n);
            iseq[j] = (p % 2 == 1) ? {dat[p][0], dat[p][1]} : dat[p];   // R6 swap at odd source
        end
        ocnt = 0;
        ready_viol = 0;
        acc_cyc = 0;
        @(posedge clk); #2;
        blk_len = LW'(n); ilv_p0 = LW'(p0); ilv_q1 = LW'(q1);
        ilv_q2 = LW'(q2); ilv_q3 = LW'(q3);
        in_valid = 1'b1;
        in_cpl = dat[0];
        i = 0;
        while (i < n) begin
            @(negedge clk);
            acc = in_ready;
            if (acc && i == n - 1) acc_cyc = cyc;
            @(posedge clk); #2;
            if (acc) begin
                i++;
                if (i < n) in_cpl = dat[i];
            end
        end
        in_valid = 1'b0;
        wait_cnt = 0;
        while (ocnt < n && wait_cnt < 2 * n + 50) begin
            @(negedge clk);
            wait_cnt++;
        end
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R9", {tag, " ready after last"}, in_ready, 1);
        chk(ready_viol == 0, "R9", {tag, " ready while busy"}, ready_viol, 0);
        chk(ocnt == n, "R8", {tag, " symbol count"}, ocnt, n);
        chk(last_cyc - first_cyc == n - 1, "R8", {tag, " consecutive"}, last_cyc - first_cyc, n - 1);
        chk(first_cyc - acc_cyc == n + 4, "R10", {tag, " latency"}, first_cyc - acc_cyc, n + 4);
        s1 = find_circ(n, 1'b0);
        s2 = find_circ(n, 1'b1);
        bad_sys = 0; bad_p1 = 0; bad_p2 = 0; bad_last = 0;
        for (int j = 0; j < n && j < ocnt; j++) begin
            r1 = ref_step(s1, dat[j]);
            r2 = ref_step(s2, iseq[j]);
            s1 = r1[4:2];
            s2 = r2[4:2];
            exp = {dat[j], r1[1:0], r2[1:0]};
            if (got_sym[j][5:4] != exp[5:4]) bad_sys++;
            if (got_sym[j][3:2] != exp[3:2]) bad_p1++;
            if (got_sym[j][1:0] != exp[1:0]) bad_p2++;
            if (got_last[j] != (j == n - 1)) bad_last++;
        end
        chk(bad_sys == 0, "R3", {tag, " systematic bits wrong"}, bad_sys, 0);
        chk(bad_p1 == 0, "R4/R7", {tag, " Y1W1 wrong"}, bad_p1, 0);
        chk(bad_p2 == 0, "R5/R6", {tag, " Y2W2 wrong"}, bad_p2, 0);
        chk(bad_last == 0, "R8", {tag, " last flag wrong"}, bad_last, 0);
    endtask

    // R2: illegal length rejected on the first couple
    task automatic bad_len(input int n, input string tag);
        int seen_out, ready_low;
        @(posedge clk); #2;
        blk_len = LW'(n);
        in_valid = 1'b1;
        in_cpl = 2'b11;
        @(negedge clk);
        chk(in_ready == 1'b1, "R2", {tag, " ready at offer"}, in_ready, 1);
        chk(len_err == 1'b0, "R2", {tag, " err before"}, len_err, 0);
        @(posedge clk); #2;
        in_valid = 1'b0;
        @(negedge clk);
        chk(len_err == 1'b1, "R2", {tag, " err pulse"}, len_err, 1);
        seen_out = 0;
        ready_low = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (out_valid || len_err) seen_out++;
            if (!in_ready) ready_low++;
        end
        chk(seen_out == 0, "R2", {tag, " no block started"}, seen_out, 0);
        chk(ready_low == 0, "R2", {tag, " ready kept"}, ready_low, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "reset ready", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "reset valid", out_valid, 0);
        chk(len_err == 1'b0, "R1", "reset err", len_err, 0);

        bad_len(56, "N56 multiple of 7");
        bad_len(55, "N55 below range");
        bad_len(2397, "N2397 above range");
        bad_len(63, "N63 multiple of 7");

        // every nonzero residue of N mod 7 (R7)
        for (int n = 57; n <= 62; n++) begin
            run_block(n, 11, n / 2 + 3, 5, n / 2 + 9, 0, $sformatf("rand%0d", n));
        end
        run_block(57, 11, 31, 5, 37, 1, "zeros");
        run_block(64, 13, 35, 7, 41, 2, "ones");
        run_block(65, 17, 33, 4, 40, 3, "alt");
        run_block(2396, 13, 1200, 600, 1800, 0, "max");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule